// File: doc/BRIEF.md
# Audio Converter Power-Up Sequencer

This block brings an audio converter out of reset in an orderly way. Once reset is released it holds the converter in low power with the quiescent-voltage-ready output low, and counts frame-clock strobes to time a selection window. If software sets the control-port enable bit inside that window, the block enters control-port mode. Software then loads settings while the power-down bit stays set, and power-up starts when that bit is cleared. If the window closes without a valid enable write, the block starts up on its own in stand-alone mode.

Power-up is a timed phase counted on the system clock. Its default length is fifty microseconds. When the pop-reduction bit is set in control-port mode, a longer ramp with its own parameter is used instead. The de-emphasis selection comes from a pin while the mode is undecided and in stand-alone mode. In control-port mode it comes from a register field.

Top module: `apu_pwrup_seq`

## Requirements
- R1: While `rst_n` is low, the control register reads 0x02 (power-down bit 1 set, all other bits 0), the status register reads 0x00 and `vq_ready` is 0.
- R2: After reset release, writes to the control register (address 0) take effect at once and read back unchanged. `vq_ready` stays 0 while the mode is undecided.
- R3: If no valid enable write has arrived by the strobe that brings the frame count to WINDOW_FRAMES, stand-alone mode is entered (status bit 3). The ramp starts on the next cycle, and `vq_ready` rises exactly CLK_PER_US*PUP_US+1 cycles after that strobe edge, whatever the pop-reduction bit holds.
- R4: A control write with bit 0 set is a valid enable write when the frame count before the edge lies in [GUARD_FRAMES, WINDOW_FRAMES-1]. This holds even when it coincides with the window-closing strobe. A valid enable write sets control-port mode (status bit 0) at that edge, and stand-alone mode never follows.
- R5: In control-port mode with the power-down bit (control bit 1) at 1, `vq_ready` stays 0 for any number of cycles or strobes.
- R6: In control-port mode with pop-reduction (control bit 2) at 0, clearing the power-down bit makes `vq_ready` rise exactly CLK_PER_US*PUP_US+1 cycles after the write edge.
- R7: With pop-reduction at 1, the same rise comes POP_RAMP_CYC+1 cycles after the write edge.
- R8: Setting the power-down bit during the ramp or while running drops `vq_ready` one cycle after the write edge and returns to low power. Later frame strobes never start a stand-alone power-up.
- R9: An enable write outside the valid window is ignored (the mode is unchanged). It sets the sticky status bit 1, which only reset clears.
- R10: `deemph_sel` encodes 00 off, 01 32 kHz, 10 44.1 kHz, 11 48 kHz. Before control-port mode it is 10 when `dem_pin` is 1 and 00 otherwise. In control-port mode it equals control bits [4:3].
- R11: The frame counter advances only on `frame_stb`, so with no strobes the window never closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; also the converter reset pin |
| frame_stb | input | 1 | One-cycle frame-clock strobe, synchronous to clk |
| dem_pin | input | 1 | De-emphasis select used before control-port mode |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address (0 control, 1 status) |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data, combinational |
| vq_ready | output | 1 | Quiescent-voltage-ready |
| deemph_sel | output | 2 | De-emphasis filter select |

## Verification
The enable write and the strobe that closes the selection window can fall in the same cycle. One function then picks control-port mode while the other would start the autonomous power-up. The bench provokes this by bringing the count to WINDOW_FRAMES-1 and then driving the strobe and the enable write together for one cycle. It judges the result from the status register, which must show control-port mode at that edge, and from `vq_ready`, which must stay low. A write one strobe later is checked separately and must be rejected with the sticky flag.

// File: rtl/apu_seq_pkg.sv
package apu_seq_pkg;

   // register addresses
   localparam int ADDR_CTRL = 0;
   localparam int ADDR_STAT = 1;

   // control register bit positions
   localparam int CTRL_CPEN  = 0;
   localparam int CTRL_PDN   = 1;
   localparam int CTRL_POP   = 2;
   localparam int CTRL_DM_LO = 3;
   localparam int CTRL_DM_HI = 4;

   // status register bit positions
   localparam int STAT_CP    = 0;
   localparam int STAT_REJ   = 1;
   localparam int STAT_READY = 2;
   localparam int STAT_SA    = 3;

   // de-emphasis codes
   localparam logic [1:0] DM_OFF = 2'b00;
   localparam logic [1:0] DM_32K = 2'b01;
   localparam logic [1:0] DM_441 = 2'b10;
   localparam logic [1:0] DM_48K = 2'b11;

   typedef enum logic [1:0] {
      ST_WAIT    = 2'd0,
      ST_CP_IDLE = 2'd1,
      ST_RAMP    = 2'd2,
      ST_RUN     = 2'd3
   } seq_state_e;

endpackage

// File: rtl/apu_frame_window.sv
module apu_frame_window #(
   parameter int WINDOW_FRAMES = 1024,
   parameter int GUARD_FRAMES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_stb,
   output logic win_open,
   output logic win_expired
);

   localparam int CW = $clog2(WINDOW_FRAMES + 1);
   localparam logic [CW-1:0] WIN_END = CW'(WINDOW_FRAMES);

   logic [CW-1:0] cnt_q;

   generate
      if (WINDOW_FRAMES < 2) begin : g_bad_window
         $error("apu_frame_window: WINDOW_FRAMES must be at least 2");
      end
      if (GUARD_FRAMES >= WINDOW_FRAMES) begin : g_bad_guard
         $error("apu_frame_window: GUARD_FRAMES must be below WINDOW_FRAMES");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (frame_stb && (cnt_q != WIN_END)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // the guard compare disappears when no guard is configured
   generate
      if (GUARD_FRAMES == 0) begin : g_no_guard
         assign win_open = (cnt_q != WIN_END);
      end else begin : g_guard
         localparam logic [CW-1:0] GUARD_V = CW'(GUARD_FRAMES);
         assign win_open = (cnt_q >= GUARD_V) && (cnt_q != WIN_END);
      end
   endgenerate

   assign win_expired = (cnt_q == WIN_END);

   AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= WIN_END) else $error("frame count beyond window"); // R3
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_stb |=> (cnt_q == $past(cnt_q))) else $error("count moved without strobe"); // R11

endmodule

// File: rtl/apu_ctrl_regs.sv
module apu_ctrl_regs
   import apu_seq_pkg::*;
#(
   parameter int ADDR_W = 2,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] status_in,
   output logic [DATA_W-1:0] rd_data,
   output logic              ctrl_pdn,
   output logic              ctrl_pop,
   output logic [1:0]        ctrl_dm,
   output logic              cpen_req
);

   localparam logic [DATA_W-1:0] CTRL_RST = DATA_W'(1) << CTRL_PDN;
   localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(ADDR_CTRL);
   localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(ADDR_STAT);

   generate
      if (DATA_W < CTRL_DM_HI + 1) begin : g_bad_width
         $error("apu_ctrl_regs: DATA_W too narrow for the control fields");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("apu_ctrl_regs: ADDR_W must be at least 1");
      end
   endgenerate

   logic [DATA_W-1:0] ctrl_q;
   logic              ctrl_wr;

   assign ctrl_wr = wr_en && (wr_addr == A_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RST;
      end else if (ctrl_wr) begin
         ctrl_q <= wr_data;
      end
   end

   assign cpen_req = ctrl_wr && wr_data[CTRL_CPEN];
   assign ctrl_pdn = ctrl_q[CTRL_PDN];
   assign ctrl_pop = ctrl_q[CTRL_POP];
   assign ctrl_dm  = ctrl_q[CTRL_DM_HI:CTRL_DM_LO];

   always_comb begin
      if (rd_addr == A_CTRL) begin
         rd_data = ctrl_q;
      end else if (rd_addr == A_STAT) begin
         rd_data = status_in;
      end else begin
         rd_data = '0;
      end
   end

   AST_PDN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> ctrl_pdn) else $error("power-down not set after reset"); // R1

endmodule

// File: rtl/apu_ramp_timer.sv
module apu_ramp_timer #(
   parameter int SHORT_CYC = 6250,
   parameter int LONG_CYC  = 250000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic long_sel,
   input  logic abort,
   output logic done
);

   localparam int MAXC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
   localparam int CW   = $clog2(MAXC + 1);
   localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_CYC - 1);
   localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_CYC - 1);

   generate
      if (SHORT_CYC < 1 || LONG_CYC < 1) begin : g_bad_len
         $error("apu_ramp_timer: ramp lengths must be at least one cycle");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] last_q;
   logic          busy_q;

   assign done = busy_q && (cnt_q == last_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         last_q <= '0;
         busy_q <= 1'b0;
      end else if (abort) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (start) begin
         cnt_q  <= '0;
         last_q <= long_sel ? LONG_LAST : SHORT_LAST;
         busy_q <= 1'b1;
      end else if (busy_q) begin
         if (done) begin
            busy_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (cnt_q <= last_q)) else $error("ramp count overran"); // R6
   AST_TMR_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> !done) else $error("done held two cycles"); // R7

endmodule

// File: rtl/apu_pwrup_seq.sv
module apu_pwrup_seq
   import apu_seq_pkg::*;
#(
   parameter int WINDOW_FRAMES = 1024,
   parameter int GUARD_FRAMES  = 2,
   parameter int CLK_PER_US    = 125,
   parameter int PUP_US        = 50,
   parameter int POP_RAMP_CYC  = 250000,
   parameter int ADDR_W        = 2,
   parameter int DATA_W        = 8,
   parameter bit OUT_FLOP      = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_stb,
   input  logic              dem_pin,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              vq_ready,
   output logic [1:0]        deemph_sel
);

   localparam int SHORT_CYC = CLK_PER_US * PUP_US;

   generate
      if (CLK_PER_US < 1 || PUP_US < 1) begin : g_bad_clk
         $error("apu_pwrup_seq: CLK_PER_US and PUP_US must be positive");
      end
      if (POP_RAMP_CYC < SHORT_CYC) begin : g_bad_pop
         $error("apu_pwrup_seq: POP_RAMP_CYC must not be shorter than the plain ramp");
      end
   endgenerate

   logic              win_open, win_expired;
   logic              ctrl_pdn, ctrl_pop, cpen_req;
   logic [1:0]        ctrl_dm;
   logic              tmr_start, tmr_long, tmr_abort, tmr_done;
   logic [DATA_W-1:0] stat_vec;
   seq_state_e        st_q, st_d;
   logic              cp_q, sa_q, rej_q;
   logic              win_ok, reject, ready_int;

   apu_frame_window #(
      .WINDOW_FRAMES (WINDOW_FRAMES),
      .GUARD_FRAMES  (GUARD_FRAMES)
   ) u_window (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_stb   (frame_stb),
      .win_open    (win_open),
      .win_expired (win_expired)
   );

   apu_ctrl_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr   (rd_addr),
      .status_in (stat_vec),
      .rd_data   (rd_data),
      .ctrl_pdn  (ctrl_pdn),
      .ctrl_pop  (ctrl_pop),
      .ctrl_dm   (ctrl_dm),
      .cpen_req  (cpen_req)
   );

   apu_ramp_timer #(
      .SHORT_CYC (SHORT_CYC),
      .LONG_CYC  (POP_RAMP_CYC)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (tmr_start),
      .long_sel (tmr_long),
      .abort    (tmr_abort),
      .done     (tmr_done)
   );

   // mode selection: a valid enable write beats the closing strobe
   assign win_ok = cpen_req && win_open && (st_q == ST_WAIT);
   assign reject = cpen_req && !cp_q && !win_ok;

   always_comb begin
      st_d      = st_q;
      tmr_start = 1'b0;
      tmr_long  = 1'b0;
      tmr_abort = 1'b0;
      case (st_q)
         ST_WAIT: begin
            if (win_ok) begin
               st_d = ST_CP_IDLE;
            end else if (win_expired) begin
               st_d      = ST_RAMP;
               tmr_start = 1'b1;
            end
         end
         ST_CP_IDLE: begin
            if (!ctrl_pdn) begin
               st_d      = ST_RAMP;
               tmr_start = 1'b1;
               tmr_long  = ctrl_pop;
            end
         end
         ST_RAMP: begin
            if (cp_q && ctrl_pdn) begin
               st_d      = ST_CP_IDLE;
               tmr_abort = 1'b1;
            end else if (tmr_done) begin
               st_d = ST_RUN;
            end
         end
         ST_RUN: begin
            if (cp_q && ctrl_pdn) begin
               st_d = ST_CP_IDLE;
            end
         end
         default: st_d = ST_WAIT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_WAIT;
         cp_q  <= 1'b0;
         sa_q  <= 1'b0;
         rej_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (win_ok) begin
            cp_q <= 1'b1;
         end
         if ((st_q == ST_WAIT) && !win_ok && win_expired) begin
            sa_q <= 1'b1;
         end
         if (reject) begin
            rej_q <= 1'b1;
         end
      end
   end

   assign ready_int = (st_q == ST_RUN);

   generate
      if (OUT_FLOP) begin : g_ready_flop
         logic ready_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ready_q <= 1'b0;
            end else begin
               ready_q <= ready_int;
            end
         end
         assign vq_ready = ready_q;
      end else begin : g_ready_comb
         assign vq_ready = ready_int;
      end
   endgenerate

   always_comb begin
      stat_vec             = '0;
      stat_vec[STAT_CP]    = cp_q;
      stat_vec[STAT_REJ]   = rej_q;
      stat_vec[STAT_READY] = ready_int;
      stat_vec[STAT_SA]    = sa_q;
   end

   assign deemph_sel = cp_q ? ctrl_dm : (dem_pin ? DM_441 : DM_OFF);

   AST_CP_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cp_q) |-> $past(win_open)) else $error("control-port mode outside window"); // R4
   AST_MODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(cp_q && sa_q)) else $error("both modes selected"); // R4
   AST_SA_ON_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sa_q) |-> $past(win_expired)) else $error("stand-alone before window end"); // R3
   AST_READY_FROM_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_int) |-> $past(tmr_done)) else $error("ready without finished ramp"); // R6
   AST_LOWPWR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_q && ctrl_pdn && $past(ctrl_pdn)) |-> !ready_int) else $error("ready while powered down"); // R5
   AST_REJ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      rej_q |=> rej_q) else $error("reject flag cleared"); // R9

endmodule

// File: tb/apu_pwrup_seq_bench.sv
`timescale 1ns/1ps
module apu_pwrup_seq_bench;

   localparam int WIN   = 16;
   localparam int GRD   = 2;
   localparam int CPU   = 2;
   localparam int PUS   = 50;
   localparam int POPC  = 300;
   localparam int SHORT = CPU * PUS;
   localparam int AW    = 2;
   localparam int DW    = 8;

   localparam int SEL_READY = 0;
   localparam int SEL_STAT  = 1;
   localparam int SEL_CTRL  = 2;
   localparam int SEL_DEEM  = 3;

   typedef struct {
      int          cyc;
      int          sel;
      logic [7:0]  val;
      string       req;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frame_stb = 1'b0;
   logic          dem_pin = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [DW-1:0] rd_data;
   logic          vq_ready;
   logic [1:0]    deemph_sel;

   int   cyc = 0;
   int   n_cmp = 0;
   int   n_bad = 0;
   int   last_stb = 0;
   bit   done_flag = 1'b0;
   exp_t exp_q[$];

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   apu_pwrup_seq #(
      .WINDOW_FRAMES (WIN),
      .GUARD_FRAMES  (GRD),
      .CLK_PER_US    (CPU),
      .PUP_US        (PUS),
      .POP_RAMP_CYC  (POPC),
      .ADDR_W        (AW),
      .DATA_W        (DW)
   ) u_apu_pwrup_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_stb  (frame_stb),
      .dem_pin    (dem_pin),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data),
      .vq_ready   (vq_ready),
      .deemph_sel (deemph_sel)
   );

   // ---------------- monitor: pops expectations and compares
   initial begin
      forever begin
         @(negedge clk);
         while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
            exp_t        e;
            logic [7:0]  act;
            e = exp_q.pop_front();
            rd_addr = (e.sel == SEL_STAT) ? AW'(1) : AW'(0);
            #1;
            case (e.sel)
               SEL_READY: act = {7'd0, vq_ready};
               SEL_DEEM:  act = {6'd0, deemph_sel};
               default:   act = rd_data;
            endcase
            n_cmp++;
            if (act !== e.val) begin
               n_bad++;
               $display("FAIL %s cycle %0d sel %0d: actual 0x%02h expected 0x%02h",
                        e.req, cyc, e.sel, act, e.val);
            end
         end
      end
   end

   // ---------------- driver helpers
   task automatic expect_rel(input int dly, input int sel, input logic [7:0] val, input string req);
      exp_t e;
      e.cyc = cyc + dly; e.sel = sel; e.val = val; e.req = req;
      exp_q.push_back(e);
   endtask

   task automatic expect_abs(input int at, input int sel, input logic [7:0] val, input string req);
      exp_t e;
      e.cyc = at; e.sel = sel; e.val = val; e.req = req;
      exp_q.push_back(e);
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic drain();
      while (exp_q.size() > 0) @(posedge clk);
      #1;
   endtask

   task automatic wr(input logic [DW-1:0] d);
      wr_addr = AW'(0);
      wr_data = d;
      wr_en   = 1'b1;
      @(posedge clk); #1;
      wr_en   = 1'b0;
   endtask

   task automatic strobe(input int n);
      for (int i = 0; i < n; i++) begin
         frame_stb = 1'b1;
         @(posedge clk); #1;
         last_stb  = cyc;
         frame_stb = 1'b0;
         repeat (3) @(posedge clk);
         #1;
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      frame_stb = 1'b0;
      wr_en = 1'b0;
      @(posedge clk); #1;
      expect_rel(0, SEL_READY, 8'h00, "R1");
      expect_rel(0, SEL_CTRL,  8'h02, "R1");
      expect_rel(0, SEL_STAT,  8'h00, "R1");
      idle(2);
      rst_n = 1'b1;
      idle(1);
   endtask

   task automatic finish_up();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // ---------------- watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done_flag) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected completion");
         finish_up();
      end
   end

   // ---------------- scenarios
   initial begin
      // A: early enable rejected, stand-alone start after the window
      dem_pin = 1'b1;
      do_reset();
      wr(8'h03);
      expect_rel(0, SEL_STAT, 8'h02, "R9");
      expect_rel(0, SEL_CTRL, 8'h03, "R2");
      wr(8'h06);
      expect_rel(0, SEL_CTRL,  8'h06, "R2");
      expect_rel(0, SEL_READY, 8'h00, "R2");
      expect_rel(0, SEL_DEEM,  8'h02, "R10");
      idle(2);
      dem_pin = 1'b0;
      expect_rel(0, SEL_DEEM, 8'h00, "R10");
      drain();
      strobe(WIN);
      expect_abs(last_stb + SHORT,     SEL_READY, 8'h00, "R3");
      expect_abs(last_stb + SHORT + 1, SEL_READY, 8'h01, "R3");
      expect_abs(last_stb + SHORT + 1, SEL_STAT,  8'h0E, "R3");
      drain();

      // B: control-port mode, power cycling and pop ramp
      dem_pin = 1'b1;
      do_reset();
      idle(200);
      expect_rel(0, SEL_STAT, 8'h00, "R11");
      drain();
      strobe(GRD);
      wr(8'h03);
      expect_rel(0, SEL_STAT, 8'h01, "R4");
      wr(8'h1A);
      expect_rel(0, SEL_DEEM, 8'h03, "R10");
      drain();
      idle(150);
      expect_rel(0, SEL_READY, 8'h00, "R5");
      drain();
      strobe(WIN + 4);
      expect_rel(0, SEL_READY, 8'h00, "R5");
      expect_rel(0, SEL_STAT,  8'h01, "R4");
      drain();
      wr(8'h18);
      expect_rel(SHORT,     SEL_READY, 8'h00, "R6");
      expect_rel(SHORT + 1, SEL_READY, 8'h01, "R6");
      drain();
      idle(5);
      wr(8'h1A);
      expect_rel(0, SEL_READY, 8'h01, "R8");
      expect_rel(1, SEL_READY, 8'h00, "R8");
      drain();
      strobe(WIN + 4);
      expect_rel(0, SEL_READY, 8'h00, "R8");
      expect_rel(0, SEL_STAT,  8'h01, "R8");
      drain();
      wr(8'h0C);
      expect_rel(0,        SEL_DEEM,  8'h01, "R10");
      expect_rel(POPC,     SEL_READY, 8'h00, "R7");
      expect_rel(POPC + 1, SEL_READY, 8'h01, "R7");
      drain();
      wr(8'h02);
      idle(3);
      wr(8'h00);
      idle(50);
      wr(8'h02);
      expect_rel(1,          SEL_READY, 8'h00, "R8");
      expect_rel(SHORT + 20, SEL_READY, 8'h00, "R8");
      drain();

      // C: enable write on the window-closing strobe wins
      dem_pin = 1'b1;
      do_reset();
      strobe(WIN - 1);
      frame_stb = 1'b1;
      wr(8'h03);
      frame_stb = 1'b0;
      expect_rel(0,         SEL_STAT,  8'h01, "R4");
      expect_rel(0,         SEL_DEEM,  8'h00, "R10");
      expect_rel(SHORT + 5, SEL_READY, 8'h00, "R4");
      expect_rel(SHORT + 5, SEL_STAT,  8'h01, "R4");
      drain();

      // D: enable write one strobe later is rejected
      do_reset();
      strobe(WIN);
      wr(8'h01);
      expect_rel(0, SEL_STAT, 8'h0A, "R9");
      expect_abs(last_stb + SHORT + 1, SEL_READY, 8'h01, "R9");
      drain();

      done_flag = 1'b1;
      finish_up();
   end

endmodule